// File: doc/BRIEF.md
# Word-Addressed Data Memory with Load/Store Path

This block is the data memory stage of a small in-order 32-bit integer pipeline. The ALU computes an effective address for every load and store as source-1 plus the immediate, in the same way it computes an add-immediate. The block takes that address together with the instruction's valid, load and store flags, the store data taken from source 2, and the destination register index. It registers these into the memory stage, which is the fourth stage of the pipeline. In that stage the single read/write port reads the addressed word and, for stores, writes it.

The memory holds whole words only. Entries are selected by address bits [5:2]. The two bits below the word offset and all bits above the index are ignored. Byte and halfword loads are handled exactly as word loads, and there is no partial-word write.

For write-back, the block returns a registered load word, a delayed load-valid flag and a delayed destination index. All three are aligned two cycles after the address stage. Reset clears the pipeline flags and the returned word, but it does not clear the storage array.

Top module: `wdmem_ls`

## Requirements
- R1: While reset is asserted and directly after it, `wb_ld_valid` is 0 and `wb_ld_data` is 0.
- R2: A cycle with `op_valid`=1 and `op_store`=1 writes `src2_data` into the entry selected by `alu_addr[5:2]`.
- R3: A cycle with `op_valid`=1 and `op_load`=1 raises `wb_ld_valid` exactly two clock edges later. In that cycle `wb_ld_data` holds the full 32-bit word of entry `alu_addr[5:2]` and `wb_rd` equals the `rd_idx` given with the load.
- R4: Address bits [1:0] and bits [31:6] have no effect on which entry is accessed. For example, address 0xABC00049 selects the same entry as address 0x8, which is entry 2.
- R5: A store presented with `op_valid`=0 leaves the memory unchanged. A later load of that entry returns the earlier contents.
- R6: When `op_load` and `op_store` are both set in one valid cycle, the load returns the entry's contents from before the write, and the store still updates the entry.
- R7: A load issued in the cycle directly after a store to the same entry returns the newly stored word.
- R8: Two edges after any cycle that is not a valid load, `wb_ld_valid` is 0. While `wb_ld_valid` stays 0, `wb_ld_data` keeps its last value.
- R9: Reset does not clear the storage array. A word stored before a reset is returned by a load after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction in the address stage is valid |
| op_load | input | 1 | Instruction is a load of any width |
| op_store | input | 1 | Instruction is a store |
| alu_addr | input | 32 | Effective address from the ALU (source-1 plus immediate) |
| src2_data | input | 32 | Store data taken from source 2 |
| rd_idx | input | 5 | Destination register index of the instruction |
| wb_ld_valid | output | 1 | Load result is valid for write-back |
| wb_rd | output | 5 | Destination index aligned with the write-back data |
| wb_ld_data | output | 32 | Loaded word, registered for write-back |

## Verification
A read and a write can hit one entry in the same memory-stage cycle. The bench provokes this by issuing one valid operation with both the load and store flags set on the same entry. The scoreboard records the expected word from its reference array before it applies the store, so the read must return the old word. A follow-up load must then see the new word. The closely related case of a store followed by a load of the same entry in the next cycle is also driven, and here the newer word is expected.

// File: rtl/wdmem_ls.sv
module wdmem_ls #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRY_BITS = 4,
  parameter int REG_BITS   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic                op_load,
  input  logic                op_store,
  input  logic [ADDR_W-1:0]   alu_addr,
  input  logic [DATA_W-1:0]   src2_data,
  input  logic [REG_BITS-1:0] rd_idx,
  output logic                wb_ld_valid,
  output logic [REG_BITS-1:0] wb_rd,
  output logic [DATA_W-1:0]   wb_ld_data
);
  localparam int ENTRIES = 1 << ENTRY_BITS;
  localparam int LSB     = $clog2(DATA_W / 8);
  localparam int MSB     = LSB + ENTRY_BITS - 1;

  logic [DATA_W-1:0]     mem [ENTRIES];
  logic                  m_ld, m_st;
  logic [ENTRY_BITS-1:0] m_idx;
  logic [DATA_W-1:0]     m_wdata;
  logic [REG_BITS-1:0]   m_rd;
  logic [DATA_W-1:0]     rd_word;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{alu_addr[ADDR_W-1:MSB+1], alu_addr[LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_ld    <= 1'b0;
      m_st    <= 1'b0;
      m_idx   <= '0;
      m_wdata <= '0;
      m_rd    <= '0;
    end else begin
      m_ld    <= op_valid && op_load;
      m_st    <= op_valid && op_store;
      m_idx   <= alu_addr[MSB:LSB];
      m_wdata <= src2_data;
      m_rd    <= rd_idx;
    end

  assign rd_word = mem[m_idx];

  always_ff @(posedge clk)
    if (m_st) mem[m_idx] <= m_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wb_ld_valid <= 1'b0;
      wb_rd       <= '0;
      wb_ld_data  <= '0;
    end else begin
      wb_ld_valid <= m_ld;
      wb_rd       <= m_rd;
      if (m_ld) wb_ld_data <= rd_word;
    end
endmodule

// File: rtl/wdmem_ls_chk.sv
module wdmem_ls_chk #(
  parameter int DATA_W   = 32,
  parameter int REG_BITS = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_valid,
  input logic                op_load,
  input logic [REG_BITS-1:0] rd_idx,
  input logic                wb_ld_valid,
  input logic [REG_BITS-1:0] wb_rd,
  input logic [DATA_W-1:0]   wb_ld_data
);
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_load) |=> ##1 wb_ld_valid); // R3
  AST_DEST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_load) |=> ##1 (wb_rd == $past(rd_idx, 2))); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_load) |=> ##1 !wb_ld_valid); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_ld_valid |-> $stable(wb_ld_data)); // R8
endmodule

bind wdmem_ls wdmem_ls_chk #(.DATA_W(DATA_W), .REG_BITS(REG_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_load(op_load),
  .rd_idx(rd_idx), .wb_ld_valid(wb_ld_valid), .wb_rd(wb_rd),
  .wb_ld_data(wb_ld_data)
);

// File: tb/wdmem_ls_test.sv
module wdmem_ls_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_load = 1'b0, op_store = 1'b0;
  logic [31:0] alu_addr = '0, src2_data = '0;
  logic [4:0]  rd_idx = '0;
  logic        wb_ld_valid;
  logic [4:0]  wb_rd;
  logic [31:0] wb_ld_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] ref_mem [16];
  logic [31:0] q_data[$];
  logic [4:0]  q_rd[$];
  string       q_tag[$];
  logic [31:0] last_ld = '0;

  always #5 clk = ~clk;

  wdmem_ls uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_load(op_load),
    .op_store(op_store), .alu_addr(alu_addr), .src2_data(src2_data),
    .rd_idx(rd_idx), .wb_ld_valid(wb_ld_valid), .wb_rd(wb_rd),
    .wb_ld_data(wb_ld_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic ld, input logic st,
                       input logic [31:0] a, input logic [31:0] d,
                       input logic [4:0] rd, input string tag);
    op_valid = v; op_load = ld; op_store = st;
    alu_addr = a; src2_data = d; rd_idx = rd;
    if (v && ld) begin
      q_data.push_back(ref_mem[a[5:2]]);
      q_rd.push_back(rd);
      q_tag.push_back(tag);
      last_ld = ref_mem[a[5:2]];
    end
    if (v && st) ref_mem[a[5:2]] = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    op_valid = 1'b0; op_load = 1'b0; op_store = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && wb_ld_valid) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R8 unexpected load valid", {31'd0, wb_ld_valid}, 32'd0);
      end else begin
        logic [31:0] ed;
        logic [4:0]  er;
        string       et;
        ed = q_data.pop_front();
        er = q_rd.pop_front();
        et = q_tag.pop_front();
        chk(wb_ld_data == ed, {et, " data"}, wb_ld_data, ed);
        chk(wb_rd == er, {et, " R3 dest"}, {27'd0, wb_rd}, {27'd0, er});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wb_ld_valid == 1'b0, "R1 valid in reset", {31'd0, wb_ld_valid}, 32'd0);
    chk(wb_ld_data == 32'd0, "R1 data in reset", wb_ld_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++)
      issue(1, 0, 1, i * 4, 32'hA500_0000 + i * 32'h0101_0101, 0, "R2");
    for (int i = 0; i < 16; i++)
      issue(1, 1, 0, i * 4, 0, 5'(i + 1), "R2 R3");
    idle(3);

    issue(1, 0, 1, 32'hABC0_0049, 32'hC0DE_0002, 0, "R4");
    issue(1, 1, 0, 32'h0000_0008, 0, 5'd20, "R4");
    issue(1, 1, 0, 32'hFFFF_FFCB, 0, 5'd21, "R4");

    issue(0, 0, 1, 32'h14, 32'hDEAD_BEEF, 0, "R5");
    issue(1, 1, 0, 32'h14, 0, 5'd5, "R5");
    issue(0, 1, 0, 32'h18, 0, 5'd6, "R8");

    issue(1, 1, 1, 32'h1C, 32'h7777_0007, 5'd9, "R6 old");
    issue(1, 1, 0, 32'h1C, 0, 5'd10, "R6 new");

    issue(1, 0, 1, 32'h24, 32'h1234_5678, 0, "R7");
    issue(1, 1, 0, 32'h24, 0, 5'd11, "R7");
    idle(4);
    chk(wb_ld_valid == 1'b0, "R8 idle valid", {31'd0, wb_ld_valid}, 32'd0);
    chk(wb_ld_data == last_ld, "R8 hold", wb_ld_data, last_ld);

    issue(1, 0, 1, 32'h2C, 32'h0BAD_F00D, 0, "R9");
    idle(3);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(wb_ld_data == 32'd0, "R1 data after reset", wb_ld_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1, 1, 0, 32'h2C, 0, 5'd12, "R9");
    idle(4);
    chk(q_data.size() == 0, "R3 all loads returned", q_data.size(), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule